// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Status Flags

This block is the arithmetic and logic stage of a small 8-bit microcontroller datapath. Each cycle it takes an operation code and two byte operands. The second operand may come from a register or from an immediate field; that choice is made upstream. From these it computes a result byte and a write-back enable. It also produces the candidate status flags, together with a mask that marks which flags the operation is allowed to change. The operations are add and subtract (plain and carry-chained), compare, the bitwise logic operations, one's and two's complement, increment, decrement, the single-bit shifts and rotates, and nibble swap.

The status flags live in a register inside the block. The flags are carry (C), zero (Z), negative (N), two's-complement overflow (V), signed test (S) and half carry (H). The register takes the masked update only on cycles where `exec` is high. The carry-chained operations read the registered flags, so a multi-byte add, subtract or compare is a plain sequence of byte operations. The result path is purely combinational from the operands and the registered flags.

Top module: `byte_alu`

## Requirements
- R1: Synchronous active-high reset clears all flags. The flag vector uses these bit positions: C=0, Z=1, N=2, V=3, S=4, H=5.
- R2: Add and add-with-carry (the carry form adds the registered C) write back the sum. They update C (carry out of bit 7), H (carry out of bit 3), V, N and Z.
- R3: Subtract, subtract-with-carry, compare and compare-with-carry compute a-b, minus the registered C for the carry forms. They update C (borrow), H (borrow into bit 4), V, N and Z. The compare forms drive the write-back enable low; the others drive it high.
- R4: For subtract-with-carry and compare-with-carry, Z becomes 0 when the result is nonzero and otherwise keeps its previous value.
- R5: AND, OR and XOR write back the bitwise result, clear V, and update Z and N; C and H keep their value.
- R6: One's complement gives 0xFF-a and sets C to 1 and V to 0. Two's complement gives 0x00-a, with C=1 when the result is nonzero, V=1 only when the result is 0x80, and H the borrow into bit 4.
- R7: Increment and decrement update Z, N and V only; C and H keep their value. V=1 when increment starts at 0x7F or decrement starts at 0x80.
- R8: S always equals N xor V, both in the next-flag output and in the flag register.
- R9: Shift left fills bit 0 with 0; rotate left fills it with the old C. Both move bit 7 into C and copy the old bit 3 into H.
- R10: Logical shift right fills bit 7 with 0, rotate right fills it with the old C, and arithmetic shift right keeps bit 7. All three move bit 0 into C, leave H unchanged, and set V to N xor C.
- R11: Nibble swap writes back the byte with its two halves exchanged and changes no flag.
- R12: The flag register changes only on a clock edge where `exec` is high, and then only the masked flags change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec | input | 1 | Commit the masked flag update this cycle |
| op | input | 5 | Operation code (`alu_op_e`) |
| opa | input | 8 | First operand, also the destination value |
| opb | input | 8 | Second operand (register or immediate) |
| result | output | 8 | Operation result |
| wr_en | output | 1 | Result should be written back |
| flg_next | output | 6 | Candidate flag values |
| flg_mask | output | 6 | Flags the operation updates |
| flg_q | output | 6 | Registered status flags |

## Verification
The bench goes after the boundaries of the arithmetic. Sums that wrap at 0xFF and at 0x7F catch a design that confuses carry with overflow or leaves out the bit-3 carry. Chained subtract and compare sequences catch a design that recomputes Z from the byte alone; such a design would report two multi-byte values as equal when only the low byte matches. Negate of 0x80 and 0x00, increment from 0x7F and decrement from 0x80 expose wrong V or C handling. Rotates run with C both set and clear, which shows a design that ignores the incoming carry. Logic, increment, swap and cycles with `exec` low reveal any flag that changes when it should have held.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DW = 8;
    localparam int NF = 6;

    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;

    typedef enum logic [4:0] {
        OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC,
        OP_AND, OP_OR, OP_XOR, OP_COM, OP_NEG, OP_INC, OP_DEC,
        OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR, OP_SWAP
    } alu_op_e;

    function automatic logic [NF-1:0] fbit(input int idx);
        logic [NF-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         c,
    output logic         h,
    output logic         v
);
    localparam int HW = W / 2;

    logic [W-1:0]  bx;
    logic          cx;
    logic [W:0]    full;
    logic [HW:0]   half;

    always_comb begin
        bx   = sub ? ~b : b;
        cx   = sub ? ~cin : cin;
        full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cx};
        half = {1'b0, a[HW-1:0]} + {1'b0, bx[HW-1:0]} + {{HW{1'b0}}, cx};
        r    = full[W-1:0];
        c    = sub ? ~full[W] : full[W];
        h    = sub ? ~half[HW] : half[HW];
        v    = (a[W-1] ~^ bx[W-1]) & (r[W-1] ^ a[W-1]);
    end
endmodule

// File: rtl/alu_unary.sv
module alu_unary
    import alu_pkg::*;
#(
    parameter int W = DW
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         c
);
    localparam int HW = W / 2;

    always_comb begin
        r = a;
        c = cin;
        unique case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_COM:  begin r = ~a; c = 1'b1; end
            OP_INC:  r = a + 1'b1;
            OP_DEC:  r = a - 1'b1;
            OP_LSL:  begin r = {a[W-2:0], 1'b0};    c = a[W-1]; end
            OP_ROL:  begin r = {a[W-2:0], cin};     c = a[W-1]; end
            OP_LSR:  begin r = {1'b0, a[W-1:1]};    c = a[0];   end
            OP_ROR:  begin r = {cin, a[W-1:1]};     c = a[0];   end
            OP_ASR:  begin r = {a[W-1], a[W-1:1]};  c = a[0];   end
            OP_SWAP: r = {a[HW-1:0], a[W-1:HW]};
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg
    import alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          exec,
    input  logic [NF-1:0] nxt,
    input  logic [NF-1:0] mask,
    output logic [NF-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (exec)
            q <= (q & ~mask) | (nxt & mask);
    end

    // R12: idle cycles leave the flags alone
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        !exec |=> $stable(q));
    // R12: unmasked flags survive a commit
    a_r12_unmasked: assert property (@(posedge clk) disable iff (rst)
        (exec && mask == '0) |=> $stable(q));
    // R8: the registered signed flag tracks N xor V
    a_r8_sign: assert property (@(posedge clk) disable iff (rst)
        q[FS] == (q[FN] ^ q[FV]));
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          exec,
    input  logic [4:0]    op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] result,
    output logic          wr_en,
    output logic [NF-1:0] flg_next,
    output logic [NF-1:0] flg_mask,
    output logic [NF-1:0] flg_q
);
    localparam logic [DW-1:0] MAXPOS = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MINNEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic [NF-1:0] M_ZNVS = fbit(FZ) | fbit(FN) | fbit(FV) | fbit(FS);
    localparam logic [NF-1:0] M_ALL  = {NF{1'b1}};

    alu_op_e       opc;
    logic          is_arith, is_sub, is_chain, is_shift;
    logic [DW-1:0] as_a, as_b, as_r, un_r;
    logic          as_cin, as_c, as_h, as_v, un_c;
    logic          fz, fn, fv, fc, fh;

    assign opc = alu_op_e'(op);

    always_comb begin
        is_arith = opc inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG};
        is_sub   = !(opc inside {OP_ADD, OP_ADC});
        is_chain = opc inside {OP_ADC, OP_SBC, OP_CPC};
        is_shift = opc inside {OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR};
        as_a     = (opc == OP_NEG) ? '0 : opa;
        as_b     = (opc == OP_NEG) ? opa : opb;
        as_cin   = is_chain & flg_q[FC];
    end

    alu_addsub #(.W(DW)) u_as (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(is_sub),
        .r(as_r), .c(as_c), .h(as_h), .v(as_v)
    );

    alu_unary #(.W(DW)) u_un (
        .op(opc), .a(opa), .b(opb), .cin(flg_q[FC]),
        .r(un_r), .c(un_c)
    );

    always_comb begin
        result = is_arith ? as_r : un_r;
        wr_en  = !(opc inside {OP_CP, OP_CPC});
        fn     = result[DW-1];
        fc     = is_arith ? as_c : un_c;
        fh     = flg_q[FH];
        fz     = (result == '0);
        if (opc inside {OP_SBC, OP_CPC})
            fz = fz & flg_q[FZ];
        if (is_arith)
            fh = as_h;
        else if (opc inside {OP_LSL, OP_ROL})
            fh = opa[DW/2-1];
        if (is_arith)
            fv = as_v;
        else if (is_shift)
            fv = fn ^ fc;
        else if (opc == OP_INC)
            fv = (opa == MAXPOS);
        else if (opc == OP_DEC)
            fv = (opa == MINNEG);
        else
            fv = 1'b0;

        flg_next        = '0;
        flg_next[FC]    = fc;
        flg_next[FZ]    = fz;
        flg_next[FN]    = fn;
        flg_next[FV]    = fv;
        flg_next[FS]    = fn ^ fv;
        flg_next[FH]    = fh;

        unique case (opc)
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: flg_mask = M_ZNVS;
            OP_COM, OP_LSR, OP_ROR, OP_ASR:        flg_mask = M_ZNVS | fbit(FC);
            OP_SWAP:                               flg_mask = '0;
            default:                               flg_mask = M_ALL;
        endcase
    end

    alu_flagreg u_fr (
        .clk(clk), .rst(rst), .exec(exec),
        .nxt(flg_next), .mask(flg_mask), .q(flg_q)
    );

    // R11: swap never touches the flags
    a_r11_swap_flags: assert property (@(posedge clk) disable iff (rst)
        (exec && opc == OP_SWAP) |=> $stable(flg_q));
    // R6: complement leaves carry set
    a_r6_com_carry: assert property (@(posedge clk) disable iff (rst)
        (exec && opc == OP_COM) |=> flg_q[FC]);
    // R5: logic operations clear overflow and keep C and H
    a_r5_logic_v: assert property (@(posedge clk) disable iff (rst)
        (exec && opc inside {OP_AND, OP_OR, OP_XOR}) |=>
            (!flg_q[FV] && $stable({flg_q[FC], flg_q[FH]})));
    // R7: increment and decrement keep C and H
    a_r7_incdec_keep: assert property (@(posedge clk) disable iff (rst)
        (exec && opc inside {OP_INC, OP_DEC}) |=> $stable({flg_q[FC], flg_q[FH]}));
    // R4: a chained compare never sets Z
    a_r4_chain_z: assert property (@(posedge clk) disable iff (rst)
        (exec && opc inside {OP_SBC, OP_CPC} && !flg_q[FZ]) |=> !flg_q[FZ]);
endmodule

// File: tb/sim_byte_alu.sv
module sim_byte_alu;
    import alu_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          exec = 1'b0;
    logic [4:0]    op = '0;
    logic [7:0]    opa = '0, opb = '0;
    logic [7:0]    result;
    logic          wr_en;
    logic [5:0]    flg_next, flg_mask, flg_q;

    int checks = 0;
    int bad = 0;
    logic [5:0] mf = '0;

    always #10 clk = ~clk;

    byte_alu u0 (
        .clk(clk), .rst(rst), .exec(exec), .op(op), .opa(opa), .opb(opb),
        .result(result), .wr_en(wr_en), .flg_next(flg_next),
        .flg_mask(flg_mask), .flg_q(flg_q)
    );

    function automatic string tag(input alu_op_e o);
        case (o)
            OP_ADD, OP_ADC:                 return "R2";
            OP_SUB, OP_CP:                  return "R3";
            OP_SBC, OP_CPC:                 return "R4";
            OP_AND, OP_OR, OP_XOR:          return "R5";
            OP_COM, OP_NEG:                 return "R6";
            OP_INC, OP_DEC:                 return "R7";
            OP_LSL, OP_ROL:                 return "R9";
            OP_LSR, OP_ROR, OP_ASR:         return "R10";
            default:                        return "R11";
        endcase
    endfunction

    function automatic int sgn(input int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    // behavioural reference for one operation
    task automatic model(input alu_op_e o, input int a, input int b, input logic [5:0] f,
                         output int r, output bit wb, output logic [5:0] nf);
        int s, cin, hs;
        nf  = f;
        wb  = 1;
        cin = (o == OP_ADC || o == OP_SBC || o == OP_CPC) ? int'(f[0]) : 0;
        r   = 0;
        case (o)
            OP_ADD, OP_ADC: begin
                s  = a + b + cin;  r = s % 256;
                nf[0] = s > 255;
                nf[5] = ((a % 16) + (b % 16) + cin) > 15;
                s  = sgn(a) + sgn(b) + cin;
                nf[3] = (s > 127) || (s < -128);
                nf[1] = (r == 0);
            end
            OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
                if (o == OP_NEG) begin b = a; a = 0; end
                s  = a - b - cin;  r = (s + 512) % 256;
                nf[0] = s < 0;
                hs = (a % 16) - (b % 16) - cin;
                nf[5] = hs < 0;
                s  = sgn(a) - sgn(b) - cin;
                nf[3] = (s > 127) || (s < -128);
                nf[1] = (o == OP_SBC || o == OP_CPC) ? (r == 0) && f[1] : (r == 0);
                wb = !(o == OP_CP || o == OP_CPC);
            end
            OP_AND, OP_OR, OP_XOR: begin
                r = (o == OP_AND) ? (a & b) : (o == OP_OR) ? (a | b) : (a ^ b);
                nf[3] = 0; nf[1] = (r == 0);
            end
            OP_COM: begin r = 255 - a; nf[0] = 1; nf[3] = 0; nf[1] = (r == 0); end
            OP_INC: begin r = (a + 1) % 256; nf[3] = (a == 127); nf[1] = (r == 0); end
            OP_DEC: begin r = (a + 255) % 256; nf[3] = (a == 128); nf[1] = (r == 0); end
            OP_LSL, OP_ROL: begin
                r = ((a * 2) % 256) + ((o == OP_ROL) ? int'(f[0]) : 0);
                nf[0] = a >= 128; nf[5] = (a / 8) % 2 == 1;
            end
            OP_LSR, OP_ROR, OP_ASR: begin
                r = a / 2;
                if (o == OP_ROR && f[0]) r += 128;
                if (o == OP_ASR && a >= 128) r += 128;
                nf[0] = a % 2 == 1;
            end
            default: r = (a % 16) * 16 + a / 16;
        endcase
        if (o != OP_SWAP) begin
            nf[2] = r >= 128;
            if (o >= OP_LSL && o <= OP_ASR) begin
                nf[3] = nf[2] ^ nf[0];
                nf[1] = (r == 0);
            end
            nf[4] = nf[2] ^ nf[3];
        end
    endtask

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic step(input alu_op_e o, input int a, input int b, input bit ex);
        int r; bit wb; logic [5:0] nf;
        @(negedge clk);
        op = o; opa = a[7:0]; opb = b[7:0]; exec = ex;
        #5;
        model(o, a, b, mf, r, wb, nf);
        chk(tag(o), "result", int'(result), r);
        chk(tag(o), "wr_en", int'(wr_en), int'(wb));        // R3 compare has no write-back
        chk("R12", "flags", int'(flg_q), int'(mf));
        chk("R8", "S", int'(flg_next[4]), int'(flg_next[2] ^ flg_next[3]));
        if (ex) mf = nf;                                     // R12 only commits on exec
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5 chk("R1", "reset flags", int'(flg_q), 0);
        // R2 carry, half carry, zero; then overflow
        step(OP_ADD, 8'hFF, 8'h01, 1);
        step(OP_ADC, 8'h7F, 8'h00, 1);
        step(OP_ADD, 8'h7F, 8'h01, 1);
        // R3/R4 multi-byte compare: 0x0100 vs 0x0001 then equal pair
        step(OP_CP,  8'h00, 8'h01, 1);
        step(OP_CPC, 8'h01, 8'h00, 1);
        step(OP_CP,  8'h05, 8'h05, 1);
        step(OP_CPC, 8'h07, 8'h07, 1);
        step(OP_SUB, 8'h01, 8'h02, 1);
        step(OP_SBC, 8'h00, 8'h00, 1);
        step(OP_SBC, 8'h10, 8'h01, 1);
        // R5 logic keeps C and H
        step(OP_SUB, 8'h10, 8'h01, 1);
        step(OP_AND, 8'hF0, 8'h0F, 1);
        step(OP_XOR, 8'h80, 8'h01, 1);
        // R6 complement, negate corners
        step(OP_COM, 8'hFF, 0, 1);
        step(OP_NEG, 8'h80, 0, 1);
        step(OP_NEG, 8'h00, 0, 1);
        step(OP_NEG, 8'h01, 0, 1);
        // R7 overflow corners
        step(OP_INC, 8'h7F, 0, 1);
        step(OP_DEC, 8'h80, 0, 1);
        step(OP_INC, 8'hFF, 0, 1);
        // R9 / R10 with carry set and cleared
        step(OP_LSL, 8'h88, 0, 1);
        step(OP_ROL, 8'h01, 0, 1);
        step(OP_ROR, 8'h02, 0, 1);
        step(OP_ROR, 8'h03, 0, 1);
        step(OP_ASR, 8'h81, 0, 1);
        step(OP_LSR, 8'h81, 0, 1);
        // R11 swap, R12 no commit
        step(OP_SWAP, 8'h3C, 0, 1);
        step(OP_ADD, 8'hFF, 8'hFF, 0);
        step(OP_NEG, 8'h80, 0, 0);
        for (int i = 0; i < 2000; i++)
            step(alu_op_e'($urandom_range(0, 18)), $urandom_range(0, 255),
                 $urandom_range(0, 255), $urandom_range(0, 3) != 0);
        @(negedge clk);
        chk("R12", "final flags", int'(flg_q), int'(mf));
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule